// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Addressing

This block lets an external SPI master read and write a small register array through a command-framed protocol. A transaction is bounded by chip enable going low and then high again. The first byte carries a direction flag in its top bit and a start address in its low seven bits. Every following byte is a data byte. Write data arrives on MOSI and is handed to the array through a one-cycle write strobe. Read data is fetched from the array and shifted out on MISO. The address advances by one after each data byte, so a single transaction can cover a run of consecutive registers.

The SPI pins are sampled by the system clock through two-flop synchronizers, and SCLK edges are found in that domain. Clock polarity and phase are static inputs, so all four SPI modes are supported. The register array sits outside the block. The block drives the address, write strobe and write data, and it reads the array's combinational read data for the current address.

Top module: `spi_regbank_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `miso`, `miso_oe` and `reg_we` are all 0.
- R2: The first byte of each transaction is a command, received MSB first. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6..0 give the start address.
- R3: In a write, each complete data byte (MSB first) produces exactly one single-cycle `reg_we` pulse. During the pulse, `reg_addr` holds the target address and `reg_wdata` holds the byte.
- R4: In a read, the register at the command's address is shifted out on `miso` MSB first. Its first bit is present before the first sampling edge of the data phase.
- R5: Each further data byte in the same transaction, whether read or write, targets the previous address plus one.
- R6: The address advances from 0x7F to 0x00.
- R7: A data byte cut short by chip enable rising is never written. The next transaction starts again with a command byte.
- R8: While the synchronized chip enable is high, `miso_oe` is 0 and `miso` is 0. While it is low, `miso_oe` is 1.
- R9: `cpol` gives the SCLK idle level (0 low, 1 high). With `cpha` = 0, data is sampled on the leading edge and changed on the trailing edge. With `cpha` = 1, the roles of the two edges swap. All four modes carry data correctly.
- R10: The SPI inputs pass through two synchronizer flops plus one edge-detect flop. The write strobe for the last bit of a byte therefore rises on the third system-clock edge after that SCLK sampling edge. SCLK half-periods must be at least four system clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sclk | input | 1 | SPI shift clock from master |
| cs_n | input | 1 | Active-low chip enable |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 when deselected |
| miso_oe | output | 1 | Output enable for an external MISO tri-state driver |
| reg_we | output | 1 | One-cycle write strobe to the register array |
| reg_addr | output | DW-1 | Current register address |
| reg_wdata | output | DW | Write data to the register array |
| reg_rdata | input | DW | Read data for `reg_addr`, combinational from the array |

## Verification
Two events can fall into the same system-clock cycle: the completion of a data byte and the end of the transaction when chip enable rises. The bench provokes this by raising chip enable partway through a data byte and also right after a full byte. It then judges the result through the write count and a read-back of the targeted register: the partial byte must leave no trace, and the full byte must be stored. A second collision is the burst address step against the read fetch. The fetch must land before the next shift edge, and this is judged by comparing each byte of a burst read, including one that wraps from 0x7F to 0x00, against the bench's model of the array.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          reg_we,
  output logic [DW-2:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int AW = DW - 1;
  localparam int CW = $clog2(DW);

  logic [2:0]    sclk_p;
  logic [1:0]    cs_p;
  logic [1:0]    mosi_p;
  logic [CW-1:0] bitcnt;
  logic [AW-1:0] rx;
  logic [DW-1:0] tx;
  logic          in_cmd;
  logic          is_wr;
  logic          fetch;
  logic          miso_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  wire cs_s   = cs_p[1];
  wire mosi_s = mosi_p[1];
  wire rise   = sclk_p[1] & ~sclk_p[2];
  wire fall   = ~sclk_p[1] & sclk_p[2];
  wire lead   = cpol ? fall : rise;
  wire trail  = cpol ? rise : fall;
  wire samp   = ~cs_s & (cpha ? trail : lead);
  wire shft   = ~cs_s & (cpha ? lead : trail);
  wire last   = (bitcnt == CW'(DW - 1));
  wire [DW-1:0] byte_in = {rx, mosi_s};

  assign miso_oe = ~cs_s;
  assign miso    = miso_oe & miso_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      in_cmd    <= 1'b1;
      is_wr     <= 1'b0;
      fetch     <= 1'b0;
      miso_r    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (cs_s) begin
      bitcnt <= '0;
      in_cmd <= 1'b1;
      fetch  <= 1'b0;
      miso_r <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we)
        reg_addr <= reg_addr + 1'b1;
      if (fetch) begin
        tx    <= reg_rdata;
        fetch <= 1'b0;
      end
      if (samp) begin
        rx     <= byte_in[AW-1:0];
        bitcnt <= bitcnt + 1'b1;
        if (last) begin
          if (in_cmd) begin
            in_cmd   <= 1'b0;
            is_wr    <= byte_in[DW-1];
            reg_addr <= byte_in[AW-1:0];
            fetch    <= ~byte_in[DW-1];
          end else if (is_wr) begin
            reg_we    <= 1'b1;
            reg_wdata <= byte_in;
          end else begin
            reg_addr <= reg_addr + 1'b1;
            fetch    <= 1'b1;
          end
        end
      end
      if (shft) begin
        miso_r <= tx[DW-1];
        tx     <= {tx[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk #(
  parameter int AW = 7,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          miso,
  input logic          miso_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [CW-1:0] bitcnt
);
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> (!miso_oe && !miso));

  assert_active_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> miso_oe);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_step_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cs_s) |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

  assert_no_write_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !reg_we);

  assert_fresh_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |-> (bitcnt == '0));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(.AW(DW-1), .CW($clog2(DW))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .miso     (miso),
  .miso_oe  (miso_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .bitcnt   (bitcnt)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [128];
  int         wr_count = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      last_wa  <= reg_addr;
      last_wd  <= reg_wdata;
      wr_count <= wr_count + 1;
    end
  end

  // {mode[1:0], addr[6:0], data[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {2'd0, 7'h05, 8'hA5}, {2'd1, 7'h06, 8'h3C}, {2'd2, 7'h07, 8'hF0},
    {2'd3, 7'h08, 8'h0F}, {2'd0, 7'h7F, 8'h81}, {2'd1, 7'h00, 8'h7E},
    {2'd2, 7'h40, 8'h00}, {2'd3, 7'h41, 8'hFF}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    cpol = m[1];
    cpha = m[0];
    sclk = m[1];
    repeat (4) half_wait();
  endtask

  task automatic xbit(input logic b, output logic r);
    if (!cpha) begin
      mosi = b; half_wait();
      sclk = ~cpol; r = miso; half_wait();
      sclk = cpol;
    end else begin
      sclk = ~cpol; mosi = b; half_wait();
      sclk = cpol; r = miso; half_wait();
    end
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
  endtask

  task automatic begin_tx();
    cs_n = 1'b0;
    half_wait();
  endtask

  task automatic end_tx();
    half_wait();
    cs_n = 1'b1;
    repeat (4) half_wait();
  endtask

  task automatic read1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    begin_tx();
    xbyte({1'b0, a}, r);
    xbyte(8'h00, d);
    end_tx();
  endtask

  initial begin
    repeat (128) ;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);
  end

  initial begin
    logic [7:0] r, d;
    int wc, k, hit;
    repeat (5) @(negedge clk);
    check("R1 miso in reset", miso, 0);
    check("R1 miso_oe in reset", miso_oe, 0);
    check("R1 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 miso after reset", miso, 0);
    check("R8 miso_oe idle", miso_oe, 0);

    // table walk: write then read back in each mode (R2 R3 R4 R9)
    foreach (VEC[v]) begin
      set_mode(VEC[v][16:15]);
      wc = wr_count;
      begin_tx();
      xbyte({1'b1, VEC[v][14:8]}, r);
      xbyte(VEC[v][7:0], r);
      end_tx();
      check("R3 one strobe per byte", wr_count - wc, 1);
      check("R3 strobe address", last_wa, VEC[v][14:8]);
      check("R3 strobe data", last_wd, VEC[v][7:0]);
      read1(VEC[v][14:8], d);
      check("R4 R9 read back", d, VEC[v][7:0]);
    end

    // R8 enable during a transaction
    set_mode(2'd0);
    begin_tx();
    check("R8 miso_oe selected", miso_oe, 1);
    xbyte({1'b0, 7'h05}, r);
    xbyte(8'h00, d);
    end_tx();
    check("R4 read mode0", d, 8'hA5);
    check("R8 miso_oe released", miso_oe, 0);

    // R5 burst write then burst read
    set_mode(2'd1);
    begin_tx();
    xbyte(8'h90, r);
    xbyte(8'hA1, r); xbyte(8'hB2, r); xbyte(8'hC3, r); xbyte(8'hD4, r);
    end_tx();
    set_mode(2'd3);
    begin_tx();
    xbyte(8'h10, r);
    xbyte(8'h00, d); check("R5 burst read 0x10", d, 8'hA1);
    xbyte(8'h00, d); check("R5 burst read 0x11", d, 8'hB2);
    xbyte(8'h00, d); check("R5 burst read 0x12", d, 8'hC3);
    xbyte(8'h00, d); check("R5 burst read 0x13", d, 8'hD4);
    end_tx();

    // R6 wrap on write and read
    set_mode(2'd2);
    begin_tx();
    xbyte(8'hFE, r);
    xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r);
    end_tx();
    check("R6 write wrap address", last_wa, 7'h00);
    read1(7'h00, d);
    check("R6 wrapped write landed at 0x00", d, 8'h33);
    set_mode(2'd0);
    begin_tx();
    xbyte(8'h7F, r);
    xbyte(8'h00, d); check("R6 read at 0x7F", d, 8'h22);
    xbyte(8'h00, d); check("R6 read wraps to 0x00", d, 8'h33);
    end_tx();

    // R7 partial byte not written, then fresh command works
    wc = wr_count;
    begin_tx();
    xbyte(8'hA0, r);
    for (int i = 0; i < 5; i++) xbit(1'b1, r[0]);
    end_tx();
    check("R7 no strobe for partial byte", wr_count - wc, 0);
    read1(7'h20, d);
    check("R7 register untouched", d, 8'(32 * 3 + 1));
    // R7 full byte then cut: stored once, second partial dropped
    wc = wr_count;
    begin_tx();
    xbyte(8'hA1, r);
    xbyte(8'h5A, r);
    for (int i = 0; i < 3; i++) xbit(1'b0, r[0]);
    end_tx();
    check("R7 only full byte strobed", wr_count - wc, 1);
    read1(7'h22, d);
    check("R7 next register untouched", d, 8'(34 * 3 + 1));

    // R10 strobe latency from last sampling edge (mode 0)
    set_mode(2'd0);
    begin_tx();
    xbyte(8'hB0, r);
    for (int i = 7; i >= 1; i--) xbit(i[0] ? 1'b0 : 1'b1, r[0]);
    mosi = 1'b1;
    half_wait();
    sclk = 1'b1;
    hit = 0;
    for (k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (reg_we && hit == 0) hit = k;
    end
    check("R10 strobe delay in cycles", hit, 3);
    half_wait();
    sclk = 1'b0;
    end_tx();
    check("R10 R2 byte MSB first", last_wd, 8'h55);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule